// File: doc/BRIEF.md
# Store-Gathering Line Buffer with Command Ring Pointer

This block sits between a CPU's uncached store path and the memory fabric. Software programs one cache-line address and sets an enable bit. From then on, each single-beat 32-bit store whose line address matches is captured into an eight-beat line buffer instead of going out on its own. When the eighth word arrives, the buffer presents the whole 32-byte line as one burst with a valid/ready handshake. A store that does not match, or that arrives while the enable bit is clear, is forwarded unchanged on a pass-through port in the same cycle. Such a store never flushes the buffer.

One line address is reserved as the command window. When the programmed line equals that window, the burst is not sent to the programmed address. It goes to a ring in memory, at the address held by a write pointer. Each accepted ring burst moves the pointer forward by one 32-byte line. When the advanced pointer reaches the top register, it is reloaded from the base register and a sticky wrap flag is raised. The next ring burst clears the flag. A register port sets the line address, the enable bit, base, top and the pointer, and reads each of them back. The line-address read also returns a read-only buffer-not-empty bit.

Top module: `wgather_top`

## Requirements
- R1: After reset the line buffer is empty, `bu_valid` is 0, and every readback select (0..4) returns zero: line address, enable, base, top, pointer and wrap flag are all cleared.
- R2: A store is captured only when the enable bit is set and `st_addr[31:5]` equals the programmed line; `st_addr[4:0]` is ignored. Words are packed in arrival order, so the k-th captured store appears at `bu_data[32k+31:32k]`.
- R3: A store that is not captured is forwarded combinationally on `pt_valid`/`pt_addr`/`pt_data` in the same cycle, and the buffered words and fill level stay unchanged.
- R4: Readback select 0 returns the line address in bits 31:5 and, in bit 0, a not-empty flag that is 1 exactly while at least one captured word is pending.
- R5: `bu_valid` rises in the cycle after the eighth word is captured, and it stays high with stable data until `bu_ready` is seen. Outside the command window, `bu_addr` equals the programmed line with bits 4:0 zero.
- R6: While the buffer is full, a store that would be captured sees `st_ready` = 0 and is not taken. Once a burst is accepted, the buffer is empty.
- R7: When the programmed line equals the command window (byte address 0x0C008000), `bu_addr` is the ring pointer (bits 25:5, all other bits zero). Each accepted burst advances the pointer by 32 bytes.
- R8: If the advanced pointer equals the top register, the pointer is loaded from base instead and the wrap flag is set. The wrap flag is readback select 4, bit 26.
- R9: The wrap flag clears on the next accepted ring burst that does not itself wrap.
- R10: A burst accepted outside the command window leaves the pointer and the wrap flag unchanged.
- R11: Register writes use `cfg_sel`. Select 0 takes the line from `cfg_wdata[31:5]`. Select 1 takes enable from bit 0. Selects 2, 3 and 4 take base, top and pointer from bits 25:5, and a write to select 4 also clears the wrap flag. Each field reads back in the same bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| st_ready | output | 1 | Store accepted (low only when a capturable store meets a full buffer) |
| pt_valid | output | 1 | Forwarded (not captured) store |
| pt_addr | output | 32 | Forwarded store address |
| pt_data | output | 32 | Forwarded store data |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 line, 1 enable, 2 base, 3 top, 4 pointer |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| bu_valid | output | 1 | Burst available |
| bu_ready | input | 1 | Burst taken by the fabric |
| bu_addr | output | 32 | Burst target byte address |
| bu_data | output | 256 | Eight packed data words, word 0 in the low bits |

## Verification
The forwarding decision and `st_ready` are combinational, so they are due in the same cycle as the store. `bu_valid` and the not-empty flag follow the edge that captures a word, and the new pointer and wrap value are visible on readback one edge after `bu_valid && bu_ready`. The bench changes inputs on the falling edge and compares every output shortly afterwards against a behavioural model. That model applies each cycle's inputs only at the next rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/wgather_pkg.sv
package wgather_pkg;

    typedef enum logic [2:0] {
        SEL_LINE = 3'd0,
        SEL_EN   = 3'd1,
        SEL_BASE = 3'd2,
        SEL_TOP  = 3'd3,
        SEL_PTR  = 3'd4
    } cfg_sel_e;

endpackage

// File: rtl/wgather_match.sv
module wgather_match #(
    parameter int ADDR_W   = 32,
    parameter int LINE_LSB = 5
) (
    input  logic                       valid,
    input  logic                       enable,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ADDR_W-LINE_LSB-1:0] line,
    output logic                       hit
);
    always_comb begin
        hit = valid && enable && (addr[ADDR_W-1:LINE_LSB] == line);
    end
endmodule

// File: rtl/wgather_pack.sv
module wgather_pack #(
    parameter int DATA_W = 32,
    parameter int BEATS  = 8,
    localparam int CNT_W = $clog2(BEATS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  logic [DATA_W-1:0]       push_data,
    input  logic                    pop,
    output logic [CNT_W-1:0]        count,
    output logic                    full,
    output logic [BEATS*DATA_W-1:0] line_data
);
    typedef struct packed {
        logic [CNT_W-1:0]               cnt;
        logic [BEATS-1:0][DATA_W-1:0]   beats;
    } pack_t;

    pack_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pop) begin
            s_d.cnt = '0;
        end else if (push && (s_q.cnt != CNT_W'(BEATS))) begin
            for (int k = 0; k < BEATS; k++) begin
                if (s_q.cnt == CNT_W'(k)) begin
                    s_d.beats[k] = push_data;
                end
            end
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count     = s_q.cnt;
    assign full      = (s_q.cnt == CNT_W'(BEATS));
    assign line_data = s_q.beats;

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(BEATS));

    assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (count == $past(count) + CNT_W'(1)));

    assert_pop_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (count == '0));
endmodule

// File: rtl/wgather_ring.sv
module wgather_ring #(
    parameter int PTR_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_base,
    input  logic             wr_top,
    input  logic             wr_ptr,
    input  logic [PTR_W-1:0] wdata,
    input  logic             advance,
    output logic [PTR_W-1:0] base,
    output logic [PTR_W-1:0] top,
    output logic [PTR_W-1:0] ptr,
    output logic             wrap
);
    typedef struct packed {
        logic [PTR_W-1:0] base;
        logic [PTR_W-1:0] top;
        logic [PTR_W-1:0] ptr;
        logic             wrap;
    } ring_t;

    ring_t r_d, r_q;
    logic [PTR_W-1:0] ptr_inc;

    always_comb begin
        r_d     = r_q;
        ptr_inc = r_q.ptr + PTR_W'(1);
        if (advance) begin
            if (ptr_inc == r_q.top) begin
                r_d.ptr  = r_q.base;
                r_d.wrap = 1'b1;
            end else begin
                r_d.ptr  = ptr_inc;
                r_d.wrap = 1'b0;
            end
        end
        if (wr_base) r_d.base = wdata;
        if (wr_top)  r_d.top  = wdata;
        if (wr_ptr) begin
            r_d.ptr  = wdata;
            r_d.wrap = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign base = r_q.base;
    assign top  = r_q.top;
    assign ptr  = r_q.ptr;
    assign wrap = r_q.wrap;

    assert_ring_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wr_ptr && !wr_base) |=>
            ((ptr == $past(ptr) + PTR_W'(1) && !wrap) || (ptr == $past(base) && wrap)));

    assert_ring_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wr_ptr && !wr_base && (ptr + PTR_W'(1) == top)) |=>
            (wrap && ptr == $past(base)));

    assert_wrap_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wr_ptr && (ptr + PTR_W'(1) != top)) |=> !wrap);
endmodule

// File: rtl/wgather_top.sv
module wgather_top #(
    parameter int               ADDR_W = 32,
    parameter int               DATA_W = 32,
    parameter int               BEATS  = 8,
    parameter int               PTR_W  = 21,
    parameter logic [ADDR_W-1:0] WINDOW = 32'h0C00_8000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [DATA_W-1:0]       st_data,
    output logic                    st_ready,
    output logic                    pt_valid,
    output logic [ADDR_W-1:0]       pt_addr,
    output logic [DATA_W-1:0]       pt_data,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_sel,
    input  logic [ADDR_W-1:0]       cfg_wdata,
    output logic [ADDR_W-1:0]       cfg_rdata,
    output logic                    bu_valid,
    input  logic                    bu_ready,
    output logic [ADDR_W-1:0]       bu_addr,
    output logic [BEATS*DATA_W-1:0] bu_data
);
    import wgather_pkg::*;

    localparam int LINE_LSB = $clog2(BEATS * DATA_W / 8);
    localparam int LINE_W   = ADDR_W - LINE_LSB;
    localparam int CNT_W    = $clog2(BEATS + 1);
    localparam int PAD_W    = ADDR_W - PTR_W - LINE_LSB;
    localparam logic [LINE_W-1:0] WIN_LINE = WINDOW[ADDR_W-1:LINE_LSB];

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    cfg_sel_e sel;

    logic              hit, push, pop, full, not_empty, ring_mode, accept;
    logic [CNT_W-1:0]  count;
    logic [PTR_W-1:0]  base, top, ptr;
    logic              wrap;

    assign sel = cfg_sel_e'(cfg_sel);

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && sel == SEL_LINE) cfg_d.line = cfg_wdata[ADDR_W-1:LINE_LSB];
        if (cfg_we && sel == SEL_EN)   cfg_d.en   = cfg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    wgather_match #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB)) u_match (
        .valid  (st_valid),
        .enable (cfg_q.en),
        .addr   (st_addr),
        .line   (cfg_q.line),
        .hit    (hit)
    );

    wgather_pack #(.DATA_W(DATA_W), .BEATS(BEATS)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (st_data),
        .pop       (pop),
        .count     (count),
        .full      (full),
        .line_data (bu_data)
    );

    wgather_ring #(.PTR_W(PTR_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_base (cfg_we && sel == SEL_BASE),
        .wr_top  (cfg_we && sel == SEL_TOP),
        .wr_ptr  (cfg_we && sel == SEL_PTR),
        .wdata   (cfg_wdata[LINE_LSB +: PTR_W]),
        .advance (accept && ring_mode),
        .base    (base),
        .top     (top),
        .ptr     (ptr),
        .wrap    (wrap)
    );

    always_comb begin
        not_empty = (count != '0);
        ring_mode = (cfg_q.line == WIN_LINE);
        st_ready  = !(hit && full);
        push      = hit && !full;
        pt_valid  = st_valid && !hit;
        pt_addr   = st_addr;
        pt_data   = st_data;
        bu_valid  = full;
        accept    = full && bu_ready;
        pop       = accept;
        if (ring_mode) begin
            bu_addr = {{PAD_W{1'b0}}, ptr, {LINE_LSB{1'b0}}};
        end else begin
            bu_addr = {cfg_q.line, {LINE_LSB{1'b0}}};
        end
        case (sel)
            SEL_LINE: cfg_rdata = {cfg_q.line, {(LINE_LSB-1){1'b0}}, not_empty};
            SEL_EN:   cfg_rdata = {{(ADDR_W-1){1'b0}}, cfg_q.en};
            SEL_BASE: cfg_rdata = {{PAD_W{1'b0}}, base, {LINE_LSB{1'b0}}};
            SEL_TOP:  cfg_rdata = {{PAD_W{1'b0}}, top, {LINE_LSB{1'b0}}};
            SEL_PTR:  cfg_rdata = {{(PAD_W-1){1'b0}}, wrap, ptr, {LINE_LSB{1'b0}}};
            default:  cfg_rdata = '0;
        endcase
    end

    assert_hold_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bu_valid && !bu_ready) |=> (bu_valid && $stable(bu_data)));

    assert_empty_no_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty |-> !bu_valid);

    assert_stall_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bu_valid && st_valid && cfg_q.en && st_addr[ADDR_W-1:LINE_LSB] == cfg_q.line)
            |-> !st_ready);

    assert_ptr_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ring_mode && !cfg_we) |=> ($stable(ptr) && $stable(wrap)));
endmodule

// File: tb/wgather_top_test.sv
module wgather_top_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n, st_valid, cfg_we, bu_ready;
    logic [31:0]  st_addr, st_data, cfg_wdata;
    logic [2:0]   cfg_sel;
    wire          st_ready, pt_valid, bu_valid;
    wire  [31:0]  pt_addr, pt_data, cfg_rdata, bu_addr;
    wire  [255:0] bu_data;

    wgather_top uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_ready(st_ready), .pt_valid(pt_valid), .pt_addr(pt_addr), .pt_data(pt_data),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bu_valid(bu_valid), .bu_ready(bu_ready), .bu_addr(bu_addr), .bu_data(bu_data)
    );

    int n_run = 0;
    int n_fail = 0;

    // behavioural reference
    logic [26:0] m_line;
    logic        m_en, m_wrap;
    logic [20:0] m_base, m_top, m_ptr;
    logic [31:0] m_q[$];
    localparam logic [26:0] WIN = 27'(32'h0C00_8000 >> 5);

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic [2:0] s);
        case (s)
            3'd0: return {m_line, 4'b0, (m_q.size() != 0)};
            3'd1: return {31'b0, m_en};
            3'd2: return {6'b0, m_base, 5'b0};
            3'd3: return {6'b0, m_top, 5'b0};
            3'd4: return {5'b0, m_wrap, m_ptr, 5'b0};
            default: return 32'b0;
        endcase
    endfunction

    task automatic cyc();
        logic hit, full, ring, accept;
        logic [255:0] ed;
        #2;
        hit  = st_valid && m_en && (st_addr[31:5] == m_line);
        full = (m_q.size() == 8);
        ring = (m_line == WIN);
        chk("R6 st_ready", 256'(st_ready), 256'(!(hit && full)));
        chk("R3 pt_valid", 256'(pt_valid), 256'(st_valid && !hit));
        if (st_valid && !hit) begin
            chk("R3 pt_addr", 256'(pt_addr), 256'(st_addr));
            chk("R3 pt_data", 256'(pt_data), 256'(st_data));
        end
        chk("R5 bu_valid", 256'(bu_valid), 256'(full));
        if (full) begin
            ed = '0;
            for (int k = 0; k < 8; k++) ed[32*k +: 32] = m_q[k];
            chk("R2 bu_data order", bu_data, ed);
            if (ring) chk("R7 bu_addr ring", 256'(bu_addr), 256'({6'b0, m_ptr, 5'b0}));
            else      chk("R5 bu_addr line", 256'(bu_addr), 256'({m_line, 5'b0}));
        end
        chk("R11 R4 R8 cfg_rdata", 256'(cfg_rdata), 256'(exp_rdata(cfg_sel)));
        @(posedge clk);
        accept = full && bu_ready;
        if (accept) begin
            if (ring) begin
                if (m_ptr + 21'd1 == m_top) begin m_ptr = m_base; m_wrap = 1'b1; end
                else begin m_ptr = m_ptr + 21'd1; m_wrap = 1'b0; end
            end
            m_q.delete();
        end else if (hit && !full) begin
            m_q.push_back(st_data);
        end
        if (cfg_we) begin
            case (cfg_sel)
                3'd0: m_line = cfg_wdata[31:5];
                3'd1: m_en   = cfg_wdata[0];
                3'd2: m_base = cfg_wdata[25:5];
                3'd3: m_top  = cfg_wdata[25:5];
                3'd4: begin m_ptr = cfg_wdata[25:5]; m_wrap = 1'b0; end
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic idle();
        st_valid = 1'b0; cfg_we = 1'b0;
        cyc();
    endtask

    task automatic store(input logic [31:0] a, input logic [31:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d; cfg_we = 1'b0;
        cyc();
        st_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic fill_ring(input logic [31:0] tagv);
        for (int k = 0; k < 8; k++) store(32'h0C00_8000 + 32'(4*k), tagv + 32'(k));
        idle();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; st_valid = 1'b0; cfg_we = 1'b0; bu_ready = 1'b0;
        st_addr = '0; st_data = '0; cfg_wdata = '0; cfg_sel = 3'd0;
        m_line = '0; m_en = 1'b0; m_wrap = 1'b0; m_base = '0; m_top = '0; m_ptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every register and the burst output clear after reset
        for (int s = 0; s < 5; s++) begin
            cfg_sel = 3'(s);
            #1;
            chk("R1 reset readback", 256'(cfg_rdata), 256'(0));
            chk("R1 reset bu_valid", 256'(bu_valid), 256'(0));
            @(negedge clk);
        end
        // normal line gathering
        wr(3'd0, 32'h1000_0040);
        wr(3'd1, 32'h1);
        cfg_sel = 3'd0;
        store(32'h1000_0040, 32'hA000_0000);
        store(32'h1000_0044, 32'hA000_0001);
        store(32'h1000_0060, 32'hDEAD_0001);        // R3 other line passes
        store(32'h1000_005F, 32'hA000_0002);        // R2 low bits ignored
        idle();
        wr(3'd1, 32'h0);
        store(32'h1000_0040, 32'hDEAD_0002);        // R3 disabled passes
        wr(3'd1, 32'h1);
        cfg_sel = 3'd0;
        for (int k = 3; k < 8; k++) store(32'h1000_0040 + 32'(4*k), 32'hA000_0000 + 32'(k));
        store(32'h1000_0048, 32'hDEAD_0003);        // R6 stalled while full
        idle();
        chk("R4 not-empty while full", 256'(cfg_rdata[0]), 256'(1));
        bu_ready = 1'b1;
        idle();
        chk("R6 empty after accept", 256'(cfg_rdata[0]), 256'(0));
        // ring mode
        wr(3'd2, 32'h0000_2000);
        wr(3'd3, 32'h0000_2040);
        wr(3'd4, 32'h0000_2000);
        wr(3'd0, 32'h0C00_8000);
        cfg_sel = 3'd4;
        fill_ring(32'hB100_0000);
        chk("R7 ptr advanced", 256'(cfg_rdata), 256'(32'h0000_2020));
        fill_ring(32'hB200_0000);
        chk("R8 wrap to base", 256'(cfg_rdata), 256'(32'h0400_2000));
        fill_ring(32'hB300_0000);
        chk("R9 wrap cleared", 256'(cfg_rdata), 256'(32'h0000_2020));
        // back to a normal line: pointer must hold
        wr(3'd0, 32'h2000_0000);
        cfg_sel = 3'd4;
        for (int k = 0; k < 8; k++) store(32'h2000_0000 + 32'(4*k), 32'hC000_0000 + 32'(k));
        idle();
        idle();
        chk("R10 ptr unchanged", 256'(cfg_rdata), 256'(32'h0000_2020));
        bu_ready = 1'b0;
        wr(3'd4, 32'h0000_2000);
        chk("R11 ptr write", 256'(cfg_rdata), 256'(32'h0000_2000));
        finish_run();
    end
endmodule